// File: doc/BRIEF.md
# Reverse-Order CRC-16 with Length Fix-Up

This block computes a CRC-16 (generator 0x1021, initial value zero, no final inversion) over a message whose bytes arrive last byte first. Rather than buffer the message and replay it in natural order, the block runs the CRC recurrence backwards. An inverse register is divided by x once per bit as each byte comes in. When the message is complete, the partial result is moved forward by the message length, counted in zero bytes. After that correction the output equals the ordinary CRC of the message read first byte to last.

The length correction has two forms, chosen per message. The linear form applies one zero byte per clock, so it takes n cycles. The logarithmic form builds x^(8n) mod P by repeated squaring and conditional multiplication, one bit of n per clock, and then does a single modular multiply. Between messages the caller pulses a clear. It streams the bytes with a valid strobe and then raises a finish strobe carrying the total byte count. It reads the CRC once the done flag rises.

Top module: `rcrc_rev16`

## Requirements
- R1: After a clear (`clr` high at a rising edge), `done` is 0 and `crc_out` is 0 from the next edge on. The same holds after reset.
- R2: Each accepted byte updates the inverse register. The register is shifted right eight times, and 0x8810 is XORed in whenever the bit shifted out is 1. The byte is then XORed into bits 15:8.
- R3: With `fast_sel` = 0 at the finish strobe, the zero-byte advance is applied one byte per clock. `done` rises exactly n+1 rising edges after the edge that samples `fin`, where n = `fin_len`.
- R4: With `fast_sel` = 1, the block forms x^(8n) mod P by square-and-multiply from p = 1 and q = x^4 (0x0010), consuming one bit of n per clock, LSB first. It then multiplies the result by the register. `done` rises b+1 edges after the finish edge, where b is the bit length of n (b = 0 for n = 0).
- R5: The bytes 0x39 down to 0x31 with n = 9 give 0x31C3. The eighteen bytes 0x39..0x31, 0x21, 0x83, 0x04, 0xFC, 0x1C, 0x9A, 0x66, 0x76, 0x43, in that arrival order and with n = 18, give 0x2848. Both advance modes give these results.
- R6: `byte_vld` and `fin` are ignored from the finish edge until the next clear. The result is unchanged.
- R7: Once `done` is 1, it stays 1 and `crc_out` stays constant until a clear.
- R8: For every n from 0 to 255, both advance modes produce the same CRC, and it equals the natural-order CRC-16 of the message.
- R9: Cycles with `byte_vld` low between bytes (frame gaps) have no effect on the result.
- R10: A clear takes priority over `byte_vld` and `fin` in the same cycle. The byte is not absorbed, and the inverse register reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Start a new message: zero the register, drop done |
| byte_vld | input | 1 | byte_in carries the next byte (reverse order) |
| byte_in | input | 8 | Message byte |
| fin | input | 1 | Finish strobe: start the length correction |
| fin_len | input | 8 | Total message length in bytes, sampled with fin |
| fast_sel | input | 1 | 1 = logarithmic correction, 0 = one zero byte per clock; sampled with fin |
| crc_out | output | 16 | Natural-order CRC, valid while done is 1 |
| done | output | 1 | Result ready; held until clr |

## Verification
The assertions assume that `fin_len` equals the number of bytes actually accepted. They also assume that a new message always starts with a clear, since the register is not zeroed on its own after done. The bench meets both assumptions. Every scenario task clears first, streams exactly `fin_len` bytes from its reference buffer, and raises `fin` alone. The only exceptions are the cycles that deliberately drive `byte_vld`/`fin` while busy or done, or together with a clear, to show that they are ignored.

// File: rtl/rcrc_pkg.sv
package rcrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SER  = 2'd1,
    ST_FAST = 2'd2,
    ST_DONE = 2'd3
  } rcrc_st_e;
endpackage

// File: rtl/rcrc_inv_acc.sv
// Inverse register: divides by x once per bit, then folds the byte into the top.
module rcrc_inv_acc #(
  parameter int unsigned W      = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [W-1:0] POLY  = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [W-1:0]      acc_o
);
  localparam logic [W-1:0] INV_POLY = {1'b1, POLY[W-1:1]};

  logic [W-1:0] acc_q, acc_d, shifted, absorbed;

  always_comb begin
    shifted = acc_q;
    for (int k = 0; k < BYTE_W; k++) begin
      shifted = shifted[0] ? ((shifted >> 1) ^ INV_POLY) : (shifted >> 1);
    end
    absorbed = shifted ^ {byte_in, {(W-BYTE_W){1'b0}}};
  end

  always_comb begin
    acc_d = acc_q;
    if (clr)          acc_d = '0;
    else if (load_en) acc_d = absorbed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/rcrc_fwd_bytes.sv
// One zero byte of ordinary CRC advance, as a chain of single-bit stages.
module rcrc_fwd_bytes #(
  parameter int unsigned W      = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [W-1:0] POLY  = 16'h1021
) (
  input  logic [W-1:0] crc_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] stage [0:BYTE_W];

  assign stage[0] = crc_i;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_step
    assign stage[g+1] = stage[g][W-1] ? ({stage[g][W-2:0], 1'b0} ^ POLY)
                                      : {stage[g][W-2:0], 1'b0};
  end

  assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/rcrc_mulmod.sv
// Carry-less product of two residues, reduced modulo the generator.
module rcrc_mulmod #(
  parameter int unsigned W     = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  logic [W-1:0] acc, run;

  always_comb begin
    acc = '0;
    run = b_i;
    for (int i = 0; i < W; i++) begin
      if (a_i[i]) acc = acc ^ run;
      run = run[W-1] ? ({run[W-2:0], 1'b0} ^ POLY) : {run[W-2:0], 1'b0};
    end
  end

  assign p_o = acc;
endmodule

// File: rtl/rcrc_rev16.sv
module rcrc_rev16 #(
  parameter int unsigned W      = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LEN_W  = 8,
  parameter logic [W-1:0] POLY  = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              fin,
  input  logic [LEN_W-1:0]  fin_len,
  input  logic              fast_sel,
  output logic [W-1:0]      crc_out,
  output logic              done
);
  import rcrc_pkg::*;

  localparam logic [W-1:0]     ONE    = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0]     Q_SEED = ONE << (BYTE_W/2);
  localparam logic [LEN_W-1:0] CNT_1  = {{(LEN_W-1){1'b0}}, 1'b1};

  rcrc_st_e        st_q, st_d;
  logic [W-1:0]    work_q, work_d;
  logic [W-1:0]    p_q, p_d, q_q, q_d;
  logic [W-1:0]    res_q, res_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic            absorb;
  logic [W-1:0]    acc_q;
  logic [W-1:0]    work_adv, q_sq, pq_prod, fin_prod;

  rcrc_inv_acc #(.W(W), .BYTE_W(BYTE_W), .POLY(POLY)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_en(absorb),
    .byte_in(byte_in), .acc_o(acc_q)
  );

  rcrc_fwd_bytes #(.W(W), .BYTE_W(BYTE_W), .POLY(POLY)) u_fwd (
    .crc_i(work_q), .crc_o(work_adv)
  );

  rcrc_mulmod #(.W(W), .POLY(POLY)) u_sq  (.a_i(q_q),  .b_i(q_q),    .p_o(q_sq));
  rcrc_mulmod #(.W(W), .POLY(POLY)) u_pq  (.a_i(q_sq), .b_i(p_q),    .p_o(pq_prod));
  rcrc_mulmod #(.W(W), .POLY(POLY)) u_fin (.a_i(p_q),  .b_i(work_q), .p_o(fin_prod));

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    work_d = work_q;
    p_d    = p_q;
    q_d    = q_q;
    res_d  = res_q;
    cnt_d  = cnt_q;
    absorb = 1'b0;
    if (clr) begin
      st_d  = ST_IDLE;
      res_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (fin) begin
            work_d = acc_q;
            cnt_d  = fin_len;
            p_d    = ONE;
            q_d    = Q_SEED;
            st_d   = fast_sel ? ST_FAST : ST_SER;
          end else begin
            absorb = byte_vld;
          end
        end
        ST_SER: begin
          if (cnt_q == '0) begin
            res_d = work_q;
            st_d  = ST_DONE;
          end else begin
            work_d = work_adv;
            cnt_d  = cnt_q - CNT_1;
          end
        end
        ST_FAST: begin
          if (cnt_q == '0) begin
            res_d = fin_prod;
            st_d  = ST_DONE;
          end else begin
            q_d   = q_sq;
            if (cnt_q[0]) p_d = pq_prod;
            cnt_d = cnt_q >> 1;
          end
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      work_q <= '0;
      p_q    <= '0;
      q_q    <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      work_q <= work_d;
      p_q    <= p_d;
      q_q    <= q_d;
      res_q  <= res_d;
      cnt_q  <= cnt_d;
    end
  end

  assign crc_out = res_q;
  assign done    = (st_q == ST_DONE);
endmodule

// File: rtl/rcrc_rev16_chk.sv
module rcrc_rev16_chk #(
  parameter int unsigned W     = 16,
  parameter int unsigned LEN_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               byte_vld,
  input logic               done,
  input logic [W-1:0]       crc_out,
  input rcrc_pkg::rcrc_st_e st,
  input logic [W-1:0]       acc,
  input logic [LEN_W-1:0]   cnt
);
  import rcrc_pkg::*;

  // R1
  clr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!done && crc_out == '0));

  // R3
  ser_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SER && cnt != '0 && !clr) |=> (st == ST_SER && cnt == $past(cnt) - 1'b1));

  // R4
  fast_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAST && cnt != '0 && !clr) |=> (st == ST_FAST && cnt == ($past(cnt) >> 1)));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && st != ST_IDLE && !clr) |=> $stable(acc));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (done && $stable(crc_out)));

  // R10
  clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st == ST_IDLE && acc == '0));
endmodule

bind rcrc_rev16 rcrc_rev16_chk #(.W(W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .byte_vld(byte_vld), .done(done),
  .crc_out(crc_out), .st(st_q), .acc(acc_q), .cnt(cnt_q)
);

// File: tb/rcrc_rev16_tb_top.sv
`timescale 1ns/1ps
module rcrc_rev16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        fin = 1'b0;
  logic [7:0]  fin_len = 8'h00;
  logic        fast_sel = 1'b0;
  logic [15:0] crc_out;
  logic        done;

  int errs = 0;
  int checks = 0;
  logic [7:0] mem [0:255];

  always #2 clk = ~clk;

  rcrc_rev16 dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .byte_vld(byte_vld), .byte_in(byte_in),
    .fin(fin), .fin_len(fin_len), .fast_sel(fast_sel), .crc_out(crc_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Natural-order CRC-16, generator 0x1021, init 0
  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      c = c ^ {mem[i], 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic int bit_len(input int n);
    int b = 0;
    for (int v = n; v != 0; v = v >> 1) b++;
    return b;
  endfunction

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // Clear, stream mem[n-1]..mem[0], optional gap before index gap_at, finish.
  task automatic run_msg(input int n, input bit fast, input int gap_at,
                         output logic [15:0] res, output int lat);
    do_clr();
    for (int i = 0; i < n; i++) begin
      if (i == gap_at) begin
        @(negedge clk); byte_vld = 1'b0; byte_in = 8'hEE;
        @(negedge clk);
        @(negedge clk);
      end
      @(negedge clk); byte_vld = 1'b1; byte_in = mem[n-1-i];
    end
    @(negedge clk); byte_vld = 1'b0; fin = 1'b1; fin_len = 8'(n); fast_sel = fast;
    @(negedge clk); fin = 1'b0;
    wait_done(lat);
    res = crc_out;
  endtask

  task automatic load_digits();
    for (int i = 0; i < 9; i++) mem[i] = 8'h31 + 8'(i);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R1 done after reset", 32'(done), 0);
    chk(crc_out == 16'h0, "R1 crc after reset", 32'(crc_out), 0);
  endtask

  task automatic t_examples();
    logic [15:0] r;
    int lat;
    logic [7:0] pre [0:8];
    load_digits();
    run_msg(9, 1'b0, 7, r, lat);
    chk(r == 16'h31C3, "R5 R9 digits serial", 32'(r), 32'h31C3);
    chk(lat == 10, "R3 serial latency n=9", lat, 10);
    run_msg(9, 1'b1, 7, r, lat);
    chk(r == 16'h31C3, "R5 digits fast", 32'(r), 32'h31C3);
    chk(lat == bit_len(9) + 1, "R4 fast latency n=9", lat, bit_len(9) + 1);
    pre = '{8'h43, 8'h76, 8'h66, 8'h9A, 8'h1C, 8'hFC, 8'h04, 8'h83, 8'h21};
    for (int i = 0; i < 9; i++) mem[i] = pre[i];
    for (int i = 0; i < 9; i++) mem[9+i] = 8'h31 + 8'(i);
    run_msg(18, 1'b0, 7, r, lat);
    chk(r == 16'h2848, "R5 R9 long serial", 32'(r), 32'h2848);
    chk(lat == 19, "R3 serial latency n=18", lat, 19);
    run_msg(18, 1'b1, 14, r, lat);
    chk(r == 16'h2848, "R5 long fast", 32'(r), 32'h2848);
    chk(lat == bit_len(18) + 1, "R4 fast latency n=18", lat, bit_len(18) + 1);
  endtask

  task automatic t_single();
    logic [15:0] r;
    int lat;
    mem[0] = 8'hA5;
    run_msg(1, 1'b1, -1, r, lat);
    chk(r == ref_crc(1), "R2 single byte", 32'(r), 32'(ref_crc(1)));
    run_msg(0, 1'b1, -1, r, lat);
    chk(r == 16'h0 && lat == 1, "R4 empty fast", 32'(r), 0);
    run_msg(0, 1'b0, -1, r, lat);
    chk(r == 16'h0 && lat == 1, "R3 empty serial", 32'(r), 0);
  endtask

  task automatic t_busy_ignore();
    int lat;
    logic [15:0] held;
    load_digits();
    do_clr();
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_in = mem[8-i];
    end
    @(negedge clk); byte_vld = 1'b0; fin = 1'b1; fin_len = 8'd9; fast_sel = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_in = 8'hFF; fin = 1'b1; fin_len = 8'd3; fast_sel = 1'b1;
    end
    @(negedge clk); byte_vld = 1'b0; fin = 1'b0;
    wait_done(lat);
    chk(crc_out == 16'h31C3, "R6 bytes ignored while busy", 32'(crc_out), 32'h31C3);
    held = crc_out;
    @(negedge clk); byte_vld = 1'b1; byte_in = 8'h12; fin = 1'b1; fin_len = 8'd1;
    @(negedge clk); byte_vld = 1'b0; fin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R7 done held", 32'(done), 1);
    chk(crc_out == held, "R7 crc held after done", 32'(crc_out), 32'(held));
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(done == 1'b0, "R1 done after clear", 32'(done), 0);
    chk(crc_out == 16'h0, "R1 crc after clear", 32'(crc_out), 0);
  endtask

  task automatic t_clr_prio();
    int lat;
    do_clr();
    @(negedge clk); clr = 1'b1; byte_vld = 1'b1; byte_in = 8'h55; fin = 1'b1; fin_len = 8'd4;
    @(negedge clk); clr = 1'b0; byte_vld = 1'b0; fin = 1'b0;
    chk(done == 1'b0, "R10 fin with clear ignored", 32'(done), 0);
    @(negedge clk); fin = 1'b1; fin_len = 8'd0; fast_sel = 1'b1;
    @(negedge clk); fin = 1'b0;
    wait_done(lat);
    chk(crc_out == 16'h0, "R10 byte with clear not absorbed", 32'(crc_out), 0);
  endtask

  task automatic t_sweep();
    logic [15:0] rs, rf, exp;
    int lat;
    logic [7:0] x = 8'h01;
    for (int i = 0; i < 256; i++) begin
      x = {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
      mem[i] = x ^ 8'(i);
    end
    for (int n = 0; n < 256; n++) begin
      exp = ref_crc(n);
      run_msg(n, 1'b0, -1, rs, lat);
      chk(rs == exp, $sformatf("R8 R3 serial n=%0d", n), 32'(rs), 32'(exp));
      run_msg(n, 1'b1, -1, rf, lat);
      chk(rf == rs, $sformatf("R8 R4 fast n=%0d", n), 32'(rf), 32'(rs));
    end
  endtask

  initial begin
    #(4 * 180000);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_examples();
    t_single();
    t_busy_ignore();
    t_clr_prio();
    t_sweep();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule